// File: doc/BRIEF.md
# Repetition Count Health Test

This block watches a multi-line noise bus and measures how long samples keep repeating. Two measures run side by side on every accepted sample. The per-line measure gives each bus line its own run counter, which grows while that line holds its previous bit. The whole-word measure uses one run counter, which grows only when every line holds its previous value at once. Because a repeat of the full word is about as unlikely as that many single-line repeats, the whole-word threshold defaults to the per-line default divided by the line count.

A run that reaches the active threshold raises a one-cycle fail flag for that measure. Separate thresholds are held for FIPS operation and for bypass operation, and `fips_mode_i` selects between them. A threshold can be made stricter at any time but can never be relaxed until reset. For each measure the block reports three values: the longest run seen in the current reporting period, the longest run seen since reset, and a saturating count of failing samples. Every run counter is kept twice, once as a plain count and once inverted. Any disagreement between the two copies sets a sticky fatal error flag.

Top module: `rep_count_test`

## Requirements
- R1: After a synchronous reset, both fail flags, the period peaks, the watermarks, the fail counts and `cntr_err_o` are zero. The per-line thresholds are `LINE_THR_RST` (32). The whole-word thresholds are `LINE_THR_RST/LINES` (8).
- R2: On each accepted sample (`enable_i` and `sample_valid_i` both high), a line's run becomes 1 if this is the first sample since enable or if the line's bit differs from the previous sample. Otherwise the run goes up by one. `line_fail_o` is high in the cycle after a sample in which any line's run is at or above the active per-line threshold.
- R3: The whole-word run goes up by one only when the entire sample equals the previous accepted sample. It restarts at 1 otherwise, and on the first sample since enable. `sym_fail_o` is high in the cycle after a sample whose whole-word run is at or above the active whole-word threshold.
- R4: Threshold slots are encoded on `thr_slot_i` as 0 = per-line FIPS, 1 = per-line bypass, 2 = whole-word FIPS, 3 = whole-word bypass. `fips_mode_i`=1 selects slots 0 and 2 onto `line_thr_o`/`sym_thr_o`. `fips_mode_i`=0 selects slots 1 and 3.
- R5: A threshold write stores `thr_wdata_i` only if it is less than or equal to the slot's current value. A larger value is ignored.
- R6: `line_peak_o`/`sym_peak_o` hold the largest run seen in the current period. With `period_end_i` high, the period restarts: the peak becomes the run of a sample accepted in that same cycle, or 0 if no sample is accepted.
- R7: `line_wmark_o`/`sym_wmark_o` hold the largest run seen since reset. They are not cleared by `period_end_i` or by disabling.
- R8: Each fail count goes up by exactly one for each sample that raises the matching fail flag, and saturates at its maximum.
- R9: While `enable_i` is low, all runs are cleared and no fail is raised. A cycle with `sample_valid_i` low leaves runs, peaks and counts unchanged.
- R10: `cntr_err_o` stays 0 while each run counter agrees with its inverted copy. Once set, it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Test enable; low clears all runs |
| fips_mode_i | input | 1 | 1 selects FIPS thresholds, 0 selects bypass thresholds |
| sample_valid_i | input | 1 | Noise sample present this cycle |
| sample_i | input | LINES | Noise bus sample |
| period_end_i | input | 1 | Starts a new reporting period |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_slot_i | input | 2 | Threshold slot to write (R4 encoding) |
| thr_wdata_i | input | CNT_W | Threshold write value |
| line_thr_o | output | CNT_W | Active per-line threshold |
| sym_thr_o | output | CNT_W | Active whole-word threshold |
| line_fail_o | output | 1 | Per-line run reached threshold |
| sym_fail_o | output | 1 | Whole-word run reached threshold |
| line_peak_o | output | CNT_W | Longest per-line run in the period |
| sym_peak_o | output | CNT_W | Longest whole-word run in the period |
| line_wmark_o | output | CNT_W | Longest per-line run since reset |
| sym_wmark_o | output | CNT_W | Longest whole-word run since reset |
| line_fail_cnt_o | output | CNT_W | Per-line failing sample count |
| sym_fail_cnt_o | output | CNT_W | Whole-word failing sample count |
| cntr_err_o | output | 1 | Sticky redundant counter mismatch |

## Verification
The hardest case to reach is a sequence in which the per-line and whole-word measures disagree. One line flips and restarts only its own run and the word run, while the other lines keep climbing past the per-line threshold. Later, a full-word repeat trips only the whole-word threshold. The stimulus table sets low thresholds first. It then steps through samples that make each measure fail alone and together, with period restarts and idle cycles placed among them. Directed steps follow: an ignored loosening write, and a disable cycle. The disable cycle shows that a repeated word after re-enable still starts a fresh run.

// File: rtl/rct_pkg.sv
package rct_pkg;
  typedef enum logic [1:0] {
    SLOT_LINE_FIPS = 2'd0,
    SLOT_LINE_BYP  = 2'd1,
    SLOT_SYM_FIPS  = 2'd2,
    SLOT_SYM_BYP   = 2'd3
  } thr_slot_e;

  localparam int NUM_SLOTS = 4;
endpackage

// File: rtl/rct_dual_cntr.sv
// Run-length counter kept twice: a plain copy and an inverted copy.
module rct_dual_cntr #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         repeat_i,
  output logic [W-1:0] next_o,
  output logic         mismatch_o
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] main_q, main_d;
  logic [W-1:0] inv_q, inv_d;

  always_comb begin
    main_d = main_q;
    if (clr_i)
      main_d = '0;
    else if (load_i)
      main_d = repeat_i ? ((main_q == MAXV) ? MAXV : main_q + ONE) : ONE;
  end

  // inverted copy counts downward so a stuck bit in either copy shows up
  always_comb begin
    inv_d = inv_q;
    if (clr_i)
      inv_d = '1;
    else if (load_i)
      inv_d = repeat_i ? ((inv_q == '0) ? '0 : inv_q - ONE) : ~ONE;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      main_q <= '0;
      inv_q  <= '1;
    end else begin
      main_q <= main_d;
      inv_q  <= inv_d;
    end
  end

  assign next_o     = main_d;
  assign mismatch_o = (main_q != ~inv_q);
endmodule

// File: rtl/rct_thr_bank.sv
// Four tighten-only thresholds and the mode selection.
module rct_thr_bank
  import rct_pkg::*;
#(
  parameter int W        = 16,
  parameter int LINE_RST = 32,
  parameter int SYM_RST  = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         we_i,
  input  logic [1:0]   slot_i,
  input  logic [W-1:0] wdata_i,
  input  logic         fips_i,
  output logic [W-1:0] line_thr_o,
  output logic [W-1:0] sym_thr_o
);
  logic [W-1:0] thr_q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [W-1:0] RST_VAL = (s >= 2) ? W'(SYM_RST) : W'(LINE_RST);
    always_ff @(posedge clk_i) begin
      if (rst_i)
        thr_q[s] <= RST_VAL;
      else if (we_i && (slot_i == 2'(s)) && (wdata_i <= thr_q[s]))
        thr_q[s] <= wdata_i;
    end
  end

  assign line_thr_o = fips_i ? thr_q[SLOT_LINE_FIPS] : thr_q[SLOT_LINE_BYP];
  assign sym_thr_o  = fips_i ? thr_q[SLOT_SYM_FIPS]  : thr_q[SLOT_SYM_BYP];
endmodule

// File: rtl/rct_stats.sv
// Period peak, watermark since reset and saturating fail count for one measure.
module rct_stats #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         take_i,
  input  logic         period_clr_i,
  input  logic [W-1:0] run_i,
  input  logic         fail_i,
  output logic [W-1:0] peak_o,
  output logic [W-1:0] wmark_o,
  output logic [W-1:0] fail_cnt_o
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      peak_o     <= '0;
      wmark_o    <= '0;
      fail_cnt_o <= '0;
    end else begin
      if (take_i) begin
        if (period_clr_i || run_i > peak_o)
          peak_o <= run_i;
        if (run_i > wmark_o)
          wmark_o <= run_i;
        if (fail_i && fail_cnt_o != MAXV)
          fail_cnt_o <= fail_cnt_o + W'(1);
      end else if (period_clr_i) begin
        peak_o <= '0;
      end
    end
  end
endmodule

// File: rtl/rep_count_test.sv
module rep_count_test
  import rct_pkg::*;
#(
  parameter int LINES        = 4,
  parameter int CNT_W        = 16,
  parameter int LINE_THR_RST = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             enable_i,
  input  logic             fips_mode_i,
  input  logic             sample_valid_i,
  input  logic [LINES-1:0] sample_i,
  input  logic             period_end_i,
  input  logic             thr_we_i,
  input  logic [1:0]       thr_slot_i,
  input  logic [CNT_W-1:0] thr_wdata_i,
  output logic [CNT_W-1:0] line_thr_o,
  output logic [CNT_W-1:0] sym_thr_o,
  output logic             line_fail_o,
  output logic             sym_fail_o,
  output logic [CNT_W-1:0] line_peak_o,
  output logic [CNT_W-1:0] sym_peak_o,
  output logic [CNT_W-1:0] line_wmark_o,
  output logic [CNT_W-1:0] sym_wmark_o,
  output logic [CNT_W-1:0] line_fail_cnt_o,
  output logic [CNT_W-1:0] sym_fail_cnt_o,
  output logic             cntr_err_o
);
  localparam int SYM_DIV     = LINE_THR_RST / LINES;
  localparam int SYM_THR_RST = (SYM_DIV < 1) ? 1 : SYM_DIV;

  logic             take;
  logic             have_prev_q;
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] line_rep;
  logic             sym_rep;
  logic [CNT_W-1:0] line_next [LINES];
  logic [LINES-1:0] line_mis;
  logic [CNT_W-1:0] sym_next;
  logic             sym_mis;
  logic [CNT_W-1:0] line_max;
  logic             line_hit, sym_hit;

  assign take = enable_i & sample_valid_i;

  always_ff @(posedge clk_i) begin
    if (rst_i || !enable_i) begin
      have_prev_q <= 1'b0;
      prev_q      <= '0;
    end else if (sample_valid_i) begin
      have_prev_q <= 1'b1;
      prev_q      <= sample_i;
    end
  end

  assign line_rep = {LINES{have_prev_q}} & ~(sample_i ^ prev_q);
  assign sym_rep  = have_prev_q & (sample_i == prev_q);

  rct_thr_bank #(
    .W(CNT_W), .LINE_RST(LINE_THR_RST), .SYM_RST(SYM_THR_RST)
  ) thr_i (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(thr_we_i), .slot_i(thr_slot_i),
    .wdata_i(thr_wdata_i), .fips_i(fips_mode_i),
    .line_thr_o(line_thr_o), .sym_thr_o(sym_thr_o)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    rct_dual_cntr #(.W(CNT_W)) cnt_i (
      .clk_i(clk_i), .rst_i(rst_i), .clr_i(!enable_i), .load_i(take),
      .repeat_i(line_rep[i]), .next_o(line_next[i]), .mismatch_o(line_mis[i])
    );
  end

  rct_dual_cntr #(.W(CNT_W)) sym_cnt_i (
    .clk_i(clk_i), .rst_i(rst_i), .clr_i(!enable_i), .load_i(take),
    .repeat_i(sym_rep), .next_o(sym_next), .mismatch_o(sym_mis)
  );

  always_comb begin
    line_max = '0;
    for (int i = 0; i < LINES; i++)
      if (line_next[i] > line_max) line_max = line_next[i];
  end

  assign line_hit = take && (line_max >= line_thr_o);
  assign sym_hit  = take && (sym_next >= sym_thr_o);

  rct_stats #(.W(CNT_W)) line_st_i (
    .clk_i(clk_i), .rst_i(rst_i), .take_i(take), .period_clr_i(period_end_i),
    .run_i(line_max), .fail_i(line_hit), .peak_o(line_peak_o),
    .wmark_o(line_wmark_o), .fail_cnt_o(line_fail_cnt_o)
  );

  rct_stats #(.W(CNT_W)) sym_st_i (
    .clk_i(clk_i), .rst_i(rst_i), .take_i(take), .period_clr_i(period_end_i),
    .run_i(sym_next), .fail_i(sym_hit), .peak_o(sym_peak_o),
    .wmark_o(sym_wmark_o), .fail_cnt_o(sym_fail_cnt_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      line_fail_o <= 1'b0;
      sym_fail_o  <= 1'b0;
      cntr_err_o  <= 1'b0;
    end else begin
      line_fail_o <= line_hit;
      sym_fail_o  <= sym_hit;
      cntr_err_o  <= cntr_err_o | (|line_mis) | sym_mis;
    end
  end
endmodule

// File: rtl/rep_count_test_chk.sv
module rep_count_test_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             enable_i,
  input logic             fips_mode_i,
  input logic             sample_valid_i,
  input logic             period_end_i,
  input logic [CNT_W-1:0] line_thr_o,
  input logic [CNT_W-1:0] sym_thr_o,
  input logic             line_fail_o,
  input logic             sym_fail_o,
  input logic [CNT_W-1:0] line_peak_o,
  input logic [CNT_W-1:0] line_wmark_o,
  input logic [CNT_W-1:0] sym_peak_o,
  input logic [CNT_W-1:0] sym_wmark_o,
  input logic [CNT_W-1:0] line_fail_cnt_o,
  input logic             cntr_err_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    rst_i |=> (!line_fail_o && !sym_fail_o && !cntr_err_o));

  // R9
  disabled_no_fail_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !enable_i |=> (!line_fail_o && !sym_fail_o));

  // R5
  line_thr_tighten_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $stable(fips_mode_i) |-> (line_thr_o <= $past(line_thr_o)));

  // R5
  sym_thr_tighten_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $stable(fips_mode_i) |-> (sym_thr_o <= $past(sym_thr_o)));

  // R8
  fail_count_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (line_fail_o && ($past(line_fail_cnt_o) != '1))
      |-> (line_fail_cnt_o == $past(line_fail_cnt_o) + CNT_W'(1)));

  // R7
  wmark_covers_peak_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (line_wmark_o >= line_peak_o) && (sym_wmark_o >= sym_peak_o));

  // R6
  period_idle_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (period_end_i && !(enable_i && sample_valid_i))
      |=> (line_peak_o == '0 && sym_peak_o == '0));

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cntr_err_o |=> cntr_err_o);
endmodule

bind rep_count_test rep_count_test_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .enable_i(enable_i), .fips_mode_i(fips_mode_i),
  .sample_valid_i(sample_valid_i), .period_end_i(period_end_i),
  .line_thr_o(line_thr_o), .sym_thr_o(sym_thr_o),
  .line_fail_o(line_fail_o), .sym_fail_o(sym_fail_o),
  .line_peak_o(line_peak_o), .line_wmark_o(line_wmark_o),
  .sym_peak_o(sym_peak_o), .sym_wmark_o(sym_wmark_o),
  .line_fail_cnt_o(line_fail_cnt_o), .cntr_err_o(cntr_err_o)
);

// File: tb/rep_count_test_tb_top.sv
module rep_count_test_tb_top;
  localparam int LINES = 4;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             enable = 1'b0;
  logic             fips = 1'b1;
  logic             valid = 1'b0;
  logic [LINES-1:0] sample = '0;
  logic             pend = 1'b0;
  logic             we = 1'b0;
  logic [1:0]       slot = '0;
  logic [CNT_W-1:0] wdata = '0;
  logic [CNT_W-1:0] line_thr, sym_thr, line_peak, sym_peak;
  logic [CNT_W-1:0] line_wmark, sym_wmark, line_fcnt, sym_fcnt;
  logic             line_fail, sym_fail, cerr;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  rep_count_test #(.LINES(LINES), .CNT_W(CNT_W), .LINE_THR_RST(32)) dut_i (
    .clk_i(clk), .rst_i(rst), .enable_i(enable), .fips_mode_i(fips),
    .sample_valid_i(valid), .sample_i(sample), .period_end_i(pend),
    .thr_we_i(we), .thr_slot_i(slot), .thr_wdata_i(wdata),
    .line_thr_o(line_thr), .sym_thr_o(sym_thr),
    .line_fail_o(line_fail), .sym_fail_o(sym_fail),
    .line_peak_o(line_peak), .sym_peak_o(sym_peak),
    .line_wmark_o(line_wmark), .sym_wmark_o(sym_wmark),
    .line_fail_cnt_o(line_fcnt), .sym_fail_cnt_o(sym_fcnt),
    .cntr_err_o(cerr)
  );

  // {valid, period_end, sample[3:0], line_fail, sym_fail, line_peak[7:0], sym_peak[7:0]}
  // per-line threshold 4, whole-word threshold 3
  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'b0000, 1'b0, 1'b0, 8'd1, 8'd1},
    {1'b1, 1'b0, 4'b0000, 1'b0, 1'b0, 8'd2, 8'd2},
    {1'b1, 1'b0, 4'b0001, 1'b0, 1'b0, 8'd3, 8'd2},
    {1'b1, 1'b0, 4'b0001, 1'b1, 1'b0, 8'd4, 8'd2},
    {1'b1, 1'b0, 4'b0001, 1'b1, 1'b1, 8'd5, 8'd3},
    {1'b1, 1'b0, 4'b1110, 1'b0, 1'b0, 8'd5, 8'd3},
    {1'b1, 1'b1, 4'b1110, 1'b0, 1'b0, 8'd2, 8'd2},
    {1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 8'd2, 8'd2},
    {1'b1, 1'b0, 4'b1110, 1'b0, 1'b1, 8'd3, 8'd3},
    {1'b1, 1'b0, 4'b1010, 1'b1, 1'b0, 8'd4, 8'd3},
    {1'b1, 1'b1, 4'b0101, 1'b0, 1'b0, 8'd1, 8'd1},
    {1'b1, 1'b0, 4'b0101, 1'b0, 1'b0, 8'd2, 8'd2}
  };

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr_thr(input logic [1:0] s, input int v);
    we = 1'b1; slot = s; wdata = CNT_W'(v);
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected at most 5000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 line_fail", int'(line_fail), 0);
    chk("R1 sym_fail", int'(sym_fail), 0);
    chk("R1 line_thr", int'(line_thr), 32);
    chk("R1 sym_thr", int'(sym_thr), 8);
    chk("R1 peaks", int'(line_peak) + int'(sym_peak), 0);
    chk("R1 wmarks+counts", int'(line_wmark) + int'(sym_wmark) + int'(line_fcnt) + int'(sym_fcnt), 0);
    chk("R1 cntr_err", int'(cerr), 0);

    // R4 slot encoding and mode selection
    wr_thr(2'd0, 4);
    wr_thr(2'd1, 6);
    wr_thr(2'd2, 3);
    wr_thr(2'd3, 5);
    fips = 1'b0;
    #1;
    chk("R4 bypass line_thr", int'(line_thr), 6);
    chk("R4 bypass sym_thr", int'(sym_thr), 5);
    fips = 1'b1;
    #1;
    chk("R4 fips line_thr", int'(line_thr), 4);
    chk("R4 fips sym_thr", int'(sym_thr), 3);

    // R5 loosening is ignored, tightening accepted
    wr_thr(2'd0, 10);
    chk("R5 loosen line ignored", int'(line_thr), 4);
    wr_thr(2'd3, 9);
    fips = 1'b0;
    #1;
    chk("R5 loosen sym bypass ignored", int'(sym_thr), 5);
    wr_thr(2'd3, 4);
    chk("R5 tighten sym bypass", int'(sym_thr), 4);
    fips = 1'b1;

    // R2 R3 R6 R9 vector table
    enable = 1'b1;
    for (int k = 0; k < NV; k++) begin
      valid  = VEC[k][23];
      pend   = VEC[k][22];
      sample = VEC[k][21:18];
      @(posedge clk); @(negedge clk);
      chk($sformatf("R2 line_fail v%0d", k), int'(line_fail), int'(VEC[k][17]));
      chk($sformatf("R3 sym_fail v%0d", k), int'(sym_fail), int'(VEC[k][16]));
      chk($sformatf("R6 line_peak v%0d", k), int'(line_peak), int'(VEC[k][15:8]));
      chk($sformatf("R6 sym_peak v%0d", k), int'(sym_peak), int'(VEC[k][7:0]));
    end
    valid = 1'b0; pend = 1'b0;

    // R7 watermarks survive period restarts; R8 fail counts
    chk("R7 line_wmark", int'(line_wmark), 5);
    chk("R7 sym_wmark", int'(sym_wmark), 3);
    chk("R8 line_fail_cnt", int'(line_fcnt), 3);
    chk("R8 sym_fail_cnt", int'(sym_fcnt), 2);

    // R9 disabled: valid samples raise no fail and leave counts alone
    enable = 1'b0; valid = 1'b1; sample = 4'b0101;
    @(posedge clk); @(negedge clk);
    chk("R9 disabled line_fail", int'(line_fail), 0);
    chk("R9 disabled sym_fail", int'(sym_fail), 0);
    chk("R9 disabled fail count", int'(line_fcnt), 3);
    // re-enable with the same word: runs restart at 1
    enable = 1'b1; pend = 1'b1;
    @(posedge clk); @(negedge clk);
    pend = 1'b0; valid = 1'b0;
    chk("R9 restart line_peak", int'(line_peak), 1);
    chk("R9 restart sym_peak", int'(sym_peak), 1);
    chk("R7 wmark kept over disable", int'(line_wmark), 5);

    // R6 idle period end clears the peaks
    pend = 1'b1;
    @(posedge clk); @(negedge clk);
    pend = 1'b0;
    chk("R6 idle clear line_peak", int'(line_peak), 0);
    chk("R6 idle clear sym_peak", int'(sym_peak), 0);

    // R10 copies agree throughout
    chk("R10 cntr_err", int'(cerr), 0);

    finish_run();
  end
endmodule